// File: doc/BRIEF.md
# Boost PFC Cycle Timing and Mode Controller

This block produces the gate pulse for the switch of a boost power-factor stage operated in discontinuous conduction. A new switching cycle starts at every cycle boundary. At that boundary the block takes in a digitized output-voltage code (percent of nominal), a rectified-line code, an ON-time command from the regulation loop and an estimate of the output load. From these it picks the ON time and period for the cycle. All times are counted in system-clock ticks.

A three-state mode machine sets the timing rules. In start-up (code 0) the period is fixed at its longest value and the ON time follows the line code. In normal (code 1) the period shrinks as the line code rises, so the switching frequency is highest at the line crest and about half as high near the zero crossing. In burst (code 2) the timing is the same as normal, but pulses are suppressed for whole line cycles. Every cycle's ON time then passes through three limits. The first is an overcurrent cap that falls as the reciprocal of the line code. The second is a maximum-duty cap. The last is a minimum ON time. A protection input forces the gate low at once and aborts the cycle. Switching resumes on a fresh cycle.

States and transitions: STARTUP→NORMAL (output reached 99 %), NORMAL→STARTUP (output under 90 %), NORMAL→BURST (load under 5 %), BURST→NORMAL (load at or above 8 %), BURST→STARTUP (output under 90 %). Reset enters STARTUP.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: While reset is asserted, gate_o and cyc_stb_o are 0 and mode_o is 0 (STARTUP). The mode encoding is 0 = STARTUP, 1 = NORMAL, 2 = BURST.
- R2: In STARTUP the mode moves to NORMAL on the first clock where vout_pct is 99 or more. At 90..98 it stays in STARTUP.
- R3: In NORMAL the mode returns to STARTUP when vout_pct drops below 90. At 90..98 it stays in NORMAL.
- R4: In STARTUP the period is PER_MAX ticks (180). The unlimited ON time is (vline_code × SU_GAIN) >> 8, with SU_GAIN = 64.
- R5: In NORMAL and BURST the period is PER_MIN + ((PER_MIN × (255 − vline_code)) >> 8) ticks, with PER_MIN = 60. The unlimited ON time is ton_cmd.
- R6: The ON time never exceeds floor(OCP_K / vline_code), with OCP_K = 4000. A line code of 0 imposes no cap.
- R7: The ON time never exceeds (period × 171) >> 8 ticks, which is about 66.8 % duty.
- R8: After the caps, an ON time below TON_MIN (6 ticks) is raised to TON_MIN.
- R9: NORMAL enters BURST when load_pct < 5. BURST leaves for NORMAL when load_pct ≥ 8, and for STARTUP when vout_pct < 90. A line-cycle counter is 0 on entry into BURST and advances on each line_sync pulse, wrapping after 3. In BURST a cycle drives its pulse only if it starts while the counter is 0.
- R10: force_off drives gate_o and cyc_stb_o low in the same cycle. On the first clock edge after release, a new cycle starts with a strobe.
- R11: cyc_stb_o is high for the first tick of each cycle. gate_o is high from that tick for exactly the ON time, and inputs are taken only at the cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of timing |
| rst_n | input | 1 | Active-low synchronous reset |
| vout_pct | input | 8 | Output voltage, percent of nominal |
| vline_code | input | 8 | Rectified line voltage code, 255 at crest |
| ton_cmd | input | 12 | ON-time command from the loop, ticks |
| load_pct | input | 8 | Estimated output power, percent of nominal |
| line_sync | input | 1 | One-tick pulse once per line cycle |
| force_off | input | 1 | Protection disable, gate off at once |
| gate_o | output | 1 | Switch gate command |
| cyc_stb_o | output | 1 | First tick of each switching cycle |
| mode_o | output | 2 | Current mode code |

## Verification
The assertions on period spacing and minimum ON length assume that force_off is either held for at least one full clock or not asserted at all, and that it is never toggled between edges. They also assume that inputs change only between clock edges. The bench changes every input one nanosecond after a rising edge and holds force_off for many ticks. It changes the voltage, line and command inputs only right after a strobe, so each measured cycle belongs to exactly one input set. The line_sync pulses are one tick wide and placed well inside a cycle, which keeps the burst counter from moving at a cycle boundary.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {
        MODE_STARTUP = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_BURST   = 2'd2
    } pfc_mode_e;
endpackage

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
    import pfc_pkg::*;
#(
    parameter int unsigned LW          = 8,
    parameter int unsigned NORM_ENTER  = 99,
    parameter int unsigned UV_LEVEL    = 90,
    parameter int unsigned BURST_ENTER = 5,
    parameter int unsigned BURST_EXIT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] vout_pct,
    input  logic [LW-1:0] load_pct,
    output pfc_mode_e     mode
);
    pfc_mode_e mode_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_STARTUP;
        else        mode <= mode_nx;
    end

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_STARTUP: if (vout_pct >= LW'(NORM_ENTER)) mode_nx = MODE_NORMAL;
            MODE_NORMAL: begin
                if (vout_pct < LW'(UV_LEVEL))          mode_nx = MODE_STARTUP;
                else if (load_pct < LW'(BURST_ENTER))  mode_nx = MODE_BURST;
            end
            MODE_BURST: begin
                if (vout_pct < LW'(UV_LEVEL))          mode_nx = MODE_STARTUP;
                else if (load_pct >= LW'(BURST_EXIT))  mode_nx = MODE_NORMAL;
            end
            default: mode_nx = MODE_STARTUP;
        endcase
    end
endmodule

// File: rtl/pfc_recip_lut.sv
module pfc_recip_lut #(
    parameter int unsigned LW    = 8,
    parameter int unsigned TW    = 12,
    parameter int unsigned OCP_K = 4000
) (
    input  logic [LW-1:0] code,
    output logic [TW-1:0] cap
);
    localparam int unsigned NE   = 2 ** LW;
    localparam int unsigned TMAX = (2 ** TW) - 1;

    logic [TW-1:0] tbl [NE];

    for (genvar i = 0; i < NE; i++) begin : g_ent
        localparam int unsigned QUO = OCP_K / ((i == 0) ? 1 : i);
        localparam int unsigned ENT = (i == 0 || QUO > TMAX) ? TMAX : QUO;
        assign tbl[i] = TW'(ENT);
    end

    assign cap = tbl[code];
endmodule

// File: rtl/pfc_timing_calc.sv
module pfc_timing_calc
    import pfc_pkg::*;
#(
    parameter int unsigned LW       = 8,
    parameter int unsigned TW       = 12,
    parameter int unsigned PER_MIN  = 60,
    parameter int unsigned PER_MAX  = 180,
    parameter int unsigned TON_MIN  = 6,
    parameter int unsigned OCP_K    = 4000,
    parameter int unsigned SU_GAIN  = 64,
    parameter int unsigned DUTY_NUM = 171,
    parameter int unsigned DUTY_SH  = 8
) (
    input  pfc_mode_e     mode,
    input  logic [LW-1:0] vline,
    input  logic [TW-1:0] ton_cmd,
    output logic [TW-1:0] per_next,
    output logic [TW-1:0] ton_next
);
    localparam int unsigned WX   = TW + LW + 8;
    localparam int unsigned LMAX = (2 ** LW) - 1;

    logic [TW-1:0] ocp_cap;
    logic [WX-1:0] per_w, raw_w, duty_w, ton_w;

    pfc_recip_lut #(.LW(LW), .TW(TW), .OCP_K(OCP_K)) u_lut (
        .code (vline),
        .cap  (ocp_cap)
    );

    always_comb begin
        if (mode == MODE_STARTUP) begin
            per_w = WX'(PER_MAX);
            raw_w = (WX'(vline) * WX'(SU_GAIN)) >> LW;
        end else begin
            per_w = WX'(PER_MIN) + ((WX'(PER_MIN) * WX'(LW'(LMAX) - vline)) >> LW);
            if (per_w > WX'(PER_MAX)) per_w = WX'(PER_MAX);
            raw_w = WX'(ton_cmd);
        end
        duty_w = (per_w * WX'(DUTY_NUM)) >> DUTY_SH;
        ton_w  = raw_w;
        if (ton_w > WX'(ocp_cap)) ton_w = WX'(ocp_cap);
        if (ton_w > duty_w)       ton_w = duty_w;
        if (ton_w < WX'(TON_MIN)) ton_w = WX'(TON_MIN);
    end

    assign per_next = TW'(per_w);
    assign ton_next = TW'(ton_w);
endmodule

// File: rtl/pfc_cycle_engine.sv
module pfc_cycle_engine #(
    parameter int unsigned TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_off,
    input  logic [TW-1:0] per_next,
    input  logic [TW-1:0] ton_next,
    input  logic          fire_next,
    output logic          gate,
    output logic          cyc_stb
);
    logic [TW-1:0] cnt, per_r, ton_r;
    logic          fire_r, run;
    logic          cyc_start;

    assign cyc_start = !force_off && (!run || (cnt == per_r - TW'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            per_r  <= '0;
            ton_r  <= '0;
            fire_r <= 1'b0;
        end else if (force_off) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (cyc_start) begin
            run    <= 1'b1;
            cnt    <= '0;
            per_r  <= per_next;
            ton_r  <= ton_next;
            fire_r <= fire_next;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

    assign gate    = run && fire_r && (cnt < ton_r) && !force_off;
    assign cyc_stb = run && (cnt == '0) && !force_off;
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned LW          = 8,
    parameter int unsigned TW          = 12,
    parameter int unsigned PER_MIN     = 60,
    parameter int unsigned PER_MAX     = 180,
    parameter int unsigned TON_MIN     = 6,
    parameter int unsigned OCP_K       = 4000,
    parameter int unsigned SU_GAIN     = 64,
    parameter int unsigned DUTY_NUM    = 171,
    parameter int unsigned DUTY_SH     = 8,
    parameter int unsigned NORM_ENTER  = 99,
    parameter int unsigned UV_LEVEL    = 90,
    parameter int unsigned BURST_ENTER = 5,
    parameter int unsigned BURST_EXIT  = 8,
    parameter int unsigned BURST_SKIP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] vout_pct,
    input  logic [LW-1:0] vline_code,
    input  logic [TW-1:0] ton_cmd,
    input  logic [LW-1:0] load_pct,
    input  logic          line_sync,
    input  logic          force_off,
    output logic          gate_o,
    output logic          cyc_stb_o,
    output logic [1:0]    mode_o
);
    localparam int unsigned BW = $clog2(BURST_SKIP + 2);

    pfc_mode_e     mode;
    logic [BW-1:0] bcnt;
    logic [TW-1:0] per_next, ton_next;
    logic          fire_next;

    pfc_mode_fsm #(
        .LW(LW), .NORM_ENTER(NORM_ENTER), .UV_LEVEL(UV_LEVEL),
        .BURST_ENTER(BURST_ENTER), .BURST_EXIT(BURST_EXIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vout_pct (vout_pct),
        .load_pct (load_pct),
        .mode     (mode)
    );

    // line-cycle skip counter for burst operation
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_BURST) bcnt <= '0;
        else if (line_sync) bcnt <= (bcnt == BW'(BURST_SKIP)) ? '0 : bcnt + BW'(1);
    end

    assign fire_next = (mode != MODE_BURST) || (bcnt == '0);

    pfc_timing_calc #(
        .LW(LW), .TW(TW), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
        .TON_MIN(TON_MIN), .OCP_K(OCP_K), .SU_GAIN(SU_GAIN),
        .DUTY_NUM(DUTY_NUM), .DUTY_SH(DUTY_SH)
    ) u_calc (
        .mode     (mode),
        .vline    (vline_code),
        .ton_cmd  (ton_cmd),
        .per_next (per_next),
        .ton_next (ton_next)
    );

    pfc_cycle_engine #(.TW(TW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .per_next  (per_next),
        .ton_next  (ton_next),
        .fire_next (fire_next),
        .gate      (gate_o),
        .cyc_stb   (cyc_stb_o)
    );

    assign mode_o = mode;
endmodule

// File: rtl/pfc_gate_ctrl_chk.sv
module pfc_gate_ctrl_chk #(
    parameter int unsigned TW      = 12,
    parameter int unsigned PER_MIN = 60,
    parameter int unsigned PER_MAX = 180,
    parameter int unsigned TON_MIN = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       force_off,
    input logic       gate_o,
    input logic       cyc_stb_o,
    input logic [1:0] mode_o
);
    logic [TW-1:0] hi_len;
    logic [TW:0]   gap;
    logic          seen_stb, dis_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len   <= '0;
            gap      <= '0;
            seen_stb <= 1'b0;
            dis_seen <= 1'b0;
        end else begin
            hi_len   <= gate_o ? ((hi_len == '1) ? hi_len : hi_len + TW'(1)) : '0;
            gap      <= cyc_stb_o ? (TW+1)'(1) : ((gap == '1) ? gap : gap + (TW+1)'(1));
            seen_stb <= seen_stb | cyc_stb_o;
            dis_seen <= cyc_stb_o ? 1'b0 : (dis_seen | force_off);
        end
    end

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    a_r9_no_startup_to_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'd0) |-> (mode_o != 2'd2));

    a_r10_off_blocks_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> (!gate_o && !cyc_stb_o));

    a_r11_rise_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> cyc_stb_o);

    a_r8_min_on_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && hi_len != '0 && !force_off) |-> (hi_len >= TW'(TON_MIN)));

    a_r5_period_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb_o && seen_stb && !dis_seen) |->
            (gap >= (TW+1)'(PER_MIN) && gap <= (TW+1)'(PER_MAX)));
endmodule

bind pfc_gate_ctrl pfc_gate_ctrl_chk #(
    .TW(TW), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .TON_MIN(TON_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_off (force_off),
    .gate_o    (gate_o),
    .cyc_stb_o (cyc_stb_o),
    .mode_o    (mode_o)
);

// File: tb/sim_pfc_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pfc_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  vout_pct = 8'd50, vline_code = 8'd200, load_pct = 8'd50;
    logic [11:0] ton_cmd = 12'd30;
    logic        line_sync = 1'b0, force_off = 1'b0;
    logic        gate_o, cyc_stb_o;
    logic [1:0]  mode_o;

    always #2.5 clk = ~clk;

    pfc_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .vout_pct(vout_pct), .vline_code(vline_code),
        .ton_cmd(ton_cmd), .load_pct(load_pct), .line_sync(line_sync),
        .force_off(force_off), .gate_o(gate_o), .cyc_stb_o(cyc_stb_o), .mode_o(mode_o)
    );

    typedef struct {
        int    per;
        int    ton;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   mon_en = 1'b0, meas_on = 1'b0, done = 1'b0;
    int   len = 0, hi = 0;
    int   m_exp = 0, bcnt_exp = 0;

    task automatic chk(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int exp_per(int m, int v);
        int p;
        if (m == 0) return 180;
        p = 60 + ((60 * (255 - v)) >> 8);
        return (p > 180) ? 180 : p;
    endfunction

    function automatic int exp_ton(int m, int v, int c);
        int p, t, ocp, duty;
        p    = exp_per(m, v);
        t    = (m == 0) ? ((v * 64) >> 8) : c;
        ocp  = (v == 0) ? 4095 : 4000 / v;
        duty = (p * 171) >> 8;
        if (t > ocp)  t = ocp;
        if (t > duty) t = duty;
        if (t < 6)    t = 6;
        return t;
    endfunction

    // monitor: measures each cycle between strobes and compares with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_stb_o) begin
                if (meas_on) begin
                    if (q.size() == 0) chk(1'b0, "R11 scoreboard empty", len, 0);
                    else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(len == e.per, {e.req, " period"}, len, e.per);
                        chk(hi == e.ton, {e.req, " ON ticks"}, hi, e.ton);
                    end
                end
                meas_on = mon_en;
                len = 1;
                hi  = gate_o ? 1 : 0;
            end else begin
                len++;
                hi += gate_o ? 1 : 0;
            end
        end
    end

    task automatic wait_strobe();
        do begin @(posedge clk); #1; end while (!cyc_stb_o);
    endtask

    task automatic run(int n, string req);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            wait_strobe();
            mon_en = 1'b1;
            e.per = exp_per(m_exp, vline_code);
            e.ton = (m_exp != 2 || bcnt_exp == 0) ? exp_ton(m_exp, vline_code, ton_cmd) : 0;
            e.req = req;
            q.push_back(e);
        end
    endtask

    task automatic set_in(int vo, int v, int c, int ld, int m, string req);
        vout_pct = 8'(vo); vline_code = 8'(v); ton_cmd = 12'(c); load_pct = 8'(ld);
        m_exp = m;
        if (m != 2) bcnt_exp = 0;
        @(posedge clk); #1;
        chk(mode_o == 2'(m), {req, " mode"}, mode_o, m);
    endtask

    task automatic pulse_sync();
        line_sync = 1'b1;
        @(posedge clk); #1;
        line_sync = 1'b0;
        bcnt_exp = (bcnt_exp == 3) ? 0 : bcnt_exp + 1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk(gate_o == 1'b0, "R1 gate in reset", gate_o, 0);
        chk(cyc_stb_o == 1'b0, "R1 strobe in reset", cyc_stb_o, 0);
        chk(mode_o == 2'd0, "R1 mode in reset", mode_o, 0);
        rst_n = 1'b1;

        run(3, "R6 start-up OCP cap");                      // per 180, ON 20
        set_in(50, 100, 30, 50, 0, "R4");
        run(3, "R4 start-up ON follows line");              // ON 25
        set_in(50, 10, 30, 50, 0, "R8");
        run(3, "R8 start-up min ON");                       // ON 6
        set_in(95, 120, 30, 50, 0, "R2 hold below 99");
        run(2, "R2 still start-up");                        // ON 30
        set_in(100, 255, 30, 50, 1, "R2 enter normal");
        run(3, "R5 crest period with R6 cap");              // per 60, ON 15
        set_in(100, 0, 30, 50, 1, "R5");
        run(3, "R5 zero-crossing period");                  // per 119, ON 30
        set_in(100, 20, 100, 50, 1, "R7");
        run(3, "R7 duty cap");                              // per 115, ON 76
        set_in(100, 50, 2, 50, 1, "R8");
        run(3, "R8 normal min ON");                         // per 108, ON 6
        set_in(92, 128, 30, 50, 1, "R3 hold above 90");
        run(2, "R3 still normal");                          // per 89, ON 30
        set_in(85, 128, 30, 50, 0, "R3 drop to start-up");
        run(2, "R3 start-up after drop");                   // per 180, ON 31

        set_in(100, 100, 30, 50, 1, "R2 re-enter normal");
        run(1, "R5 normal");
        set_in(100, 100, 30, 3, 2, "R9 enter burst");
        run(2, "R9 burst firing cycle");                    // per 96, ON 30
        pulse_sync();
        run(2, "R9 burst skipped cycle");                   // ON 0
        pulse_sync();
        pulse_sync();
        run(1, "R9 burst still skipped");
        pulse_sync();
        run(2, "R9 burst wrap fires again");
        set_in(100, 100, 30, 10, 1, "R9 exit burst");
        run(2, "R9 normal after burst");

        // protection disable in the middle of a pulse
        wait_strobe();
        mon_en = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(gate_o == 1'b1, "R11 gate high inside ON", gate_o, 1);
        force_off = 1'b1;
        #1;
        chk(gate_o == 1'b0, "R10 gate drops at once", gate_o, 0);
        begin
            int bad = 0;
            for (int k = 0; k < 200; k++) begin
                @(posedge clk); #1;
                if (gate_o || cyc_stb_o) bad++;
            end
            chk(bad == 0, "R10 held off", bad, 0);
        end
        force_off = 1'b0;
        @(posedge clk); #1;
        chk(cyc_stb_o == 1'b1, "R10 fresh cycle strobe", cyc_stb_o, 1);
        chk(gate_o == 1'b1, "R10 fresh cycle gate", gate_o, 1);
        mon_en = 1'b1;
        begin
            exp_t e;
            e.per = 96; e.ton = 30; e.req = "R10 full cycle after release";
            q.push_back(e);
        end
        run(2, "R11 steady after release");
        wait_strobe();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R11 watchdog expired", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule